// File: doc/BRIEF.md
# Bit-Slice Integer ALU with Signed Less-Than

This block is a purely combinational integer arithmetic logic unit for a processor datapath. It takes two operands of `WIDTH` bits and a 3-bit operation code. It returns a result word, a flag that is high when that result is all zeros, and a signed overflow flag. The supported operations are bitwise AND, bitwise OR, addition, subtraction and a signed less-than test.

The datapath is a row of identical one-bit slices joined by a ripple carry chain. Each slice holds a full adder, an optional inverter on its `b` input, and a four-way output selector. Bit 2 of the operation code drives two things at once: it inverts `b` in every slice, and it is the carry into bit 0. Subtraction is therefore the addition of the two's complement of `b`.

The top slice also works out the overflow from its carry-in and carry-out. It forms the less-than decision as the sign of `a - b` exclusive-ORed with that overflow. This decision is routed back to the less-than input of slice 0, so the comparison result appears in bit 0 and every other bit reads zero.

Top module: `alu_slt_core`

## Requirements
- R1: With op = 3'b000, result is the bitwise AND of a and b.
- R2: With op = 3'b001, result is the bitwise OR of a and b.
- R3: With op = 3'b010, result is (a + b) modulo 2^WIDTH.
- R4: With op = 3'b110, result is (a - b) modulo 2^WIDTH.
- R5: With op = 3'b111, result bit 0 is 1 when a < b as signed two's complement numbers, and 0 otherwise. Result bits WIDTH-1 down to 1 are 0.
- R6: The less-than result of R5 is correct even when a - b overflows, for example with a at the most positive value and b at the most negative value.
- R7: For every operation, zero is 1 exactly when all result bits are 0.
- R8: With op = 3'b010, overflow is 1 exactly when a and b have the same sign bit and the sign bit of the result differs from it.
- R9: With op = 3'b110, overflow is 1 exactly when a and b have different sign bits and the sign bit of the result differs from the sign bit of a.
- R10: With op = 3'b000, 3'b001 or 3'b111, overflow is 0.
- R11: The carry out of the top bit does not affect result, zero or overflow. For example, adding all-ones to 1 gives result 0, zero 1 and overflow 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| op | input | 3 | Operation code (see R1 to R5) |
| result | output | WIDTH | Operation result |
| zero | output | 1 | High when result is all zeros |
| overflow | output | 1 | Signed overflow of add or subtract |

## Verification
The bench builds two copies of the unit. The first uses the default WIDTH of 32 and receives seeded random operands mixed with directed extremes: the most positive and most negative values, all-ones, equal operands, and sign-boundary pairs. The second copy has WIDTH set to 4, which is small enough to sweep every operand pair under every defined operation code. That sweep covers every overflow combination, every carry-out case and every less-than outcome, including those where the subtraction overflows.

// File: rtl/alu_pkg.sv
// Shared definitions for the bit-slice ALU: operation codes and the
// per-slice output selector encoding. Bit 2 of an operation code is
// both the b-inversion control and the carry into bit 0.
package alu_pkg;

    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_op_e;

    // Output selector of one slice, taken from op[1:0]
    typedef enum logic [1:0] {
        SEL_AND  = 2'b00,
        SEL_OR   = 2'b01,
        SEL_SUM  = 2'b10,
        SEL_LESS = 2'b11
    } slice_sel_e;

endpackage

// File: rtl/alu_bit_slice.sv
// One-bit ALU slice: optional inversion of b, full adder and a four-way
// output selector. Assumes the less input is driven by the top slice
// for bit 0 and is tied low elsewhere.
module alu_bit_slice
    import alu_pkg::*;
(
    input  logic       a_bit,
    input  logic       b_bit,
    input  logic       b_invert,
    input  logic       carry_in,
    input  logic       less_in,
    input  logic [1:0] sel,
    output logic       res_bit,
    output logic       carry_out
);

    logic b_eff;
    logic sum_bit;

    // Operand conditioning and full-adder equations
    always_comb begin
        b_eff     = b_bit ^ b_invert;
        sum_bit   = a_bit ^ b_eff ^ carry_in;
        carry_out = (a_bit & b_eff) | (a_bit & carry_in) | (b_eff & carry_in);
    end

    // Output selector driven by the low operation-code bits
    always_comb begin
        case (slice_sel_e'(sel))
            SEL_AND: res_bit = a_bit & b_eff;
            SEL_OR:  res_bit = a_bit | b_eff;
            SEL_SUM: res_bit = sum_bit;
            default: res_bit = less_in;
        endcase
    end

endmodule

// File: rtl/alu_msb_slice.sv
// Most significant slice: the same datapath as a normal slice, plus the
// signed overflow (carry in xor carry out) and the signed less-than
// decision (adder sign xor overflow). Its carry out is kept internal.
module alu_msb_slice
    import alu_pkg::*;
(
    input  logic       a_bit,
    input  logic       b_bit,
    input  logic       b_invert,
    input  logic       carry_in,
    input  logic [1:0] sel,
    output logic       res_bit,
    output logic       set_less,
    output logic       ovf_raw
);

    logic sum_bit;
    logic carry_out;

    alu_bit_slice u_core (
        .a_bit     (a_bit),
        .b_bit     (b_bit),
        .b_invert  (b_invert),
        .carry_in  (carry_in),
        .less_in   (1'b0),
        .sel       (SEL_SUM),
        .res_bit   (sum_bit),
        .carry_out (carry_out)
    );

    // Overflow and corrected sign for the less-than decision
    always_comb begin
        ovf_raw  = carry_in ^ carry_out;
        set_less = sum_bit ^ ovf_raw;
    end

    // Top result bit: sum or logic, and zero in less-than mode
    always_comb begin
        case (slice_sel_e'(sel))
            SEL_AND: res_bit = a_bit & (b_bit ^ b_invert);
            SEL_OR:  res_bit = a_bit | (b_bit ^ b_invert);
            SEL_SUM: res_bit = sum_bit;
            default: res_bit = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_zero_detect.sv
// All-zero detector over a result word, built as a two-level OR tree
// of GROUP-bit chunks. Assumes WIDTH >= 1.
module alu_zero_detect #(
    parameter int WIDTH = 32,
    parameter int GROUP = 8
) (
    input  logic [WIDTH-1:0] word,
    output logic             is_zero
);

    localparam int NGROUPS = (WIDTH + GROUP - 1) / GROUP;
    localparam int PADDED  = NGROUPS * GROUP;

    logic [PADDED-1:0]  padded;
    logic [NGROUPS-1:0] group_any;

    // Pad the word to a whole number of groups
    always_comb begin
        padded             = '0;
        padded[WIDTH-1:0]  = word;
    end

    for (genvar g = 0; g < NGROUPS; g++) begin : g_group
        assign group_any[g] = |padded[g*GROUP +: GROUP];
    end

    // Final level of the OR tree
    assign is_zero = ~|group_any;

endmodule

// File: rtl/alu_slt_core.sv
// Combinational ALU of WIDTH one-bit slices with a ripple carry chain.
// op[2] inverts b and is the carry into bit 0. op[1:0] selects the
// slice output. The top slice's less-than bit feeds slice 0.
// Assumes WIDTH >= 2.
module alu_slt_core
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [2:0]       op,
    output logic [WIDTH-1:0] result,
    output logic             zero,
    output logic             overflow
);

    localparam int MSB = WIDTH - 1;

    logic [MSB:0] carry;
    logic         set_less;
    logic         ovf_raw;
    logic         arith_op;

    assign carry[0] = op[2];

    for (genvar i = 0; i < MSB; i++) begin : g_slice
        if (i == 0) begin : g_lsb
            alu_bit_slice u_slice (
                .a_bit     (a[i]),
                .b_bit     (b[i]),
                .b_invert  (op[2]),
                .carry_in  (carry[i]),
                .less_in   (set_less),
                .sel       (op[1:0]),
                .res_bit   (result[i]),
                .carry_out (carry[i+1])
            );
        end else begin : g_mid
            alu_bit_slice u_slice (
                .a_bit     (a[i]),
                .b_bit     (b[i]),
                .b_invert  (op[2]),
                .carry_in  (carry[i]),
                .less_in   (1'b0),
                .sel       (op[1:0]),
                .res_bit   (result[i]),
                .carry_out (carry[i+1])
            );
        end
    end

    alu_msb_slice u_msb (
        .a_bit    (a[MSB]),
        .b_bit    (b[MSB]),
        .b_invert (op[2]),
        .carry_in (carry[MSB]),
        .sel      (op[1:0]),
        .res_bit  (result[MSB]),
        .set_less (set_less),
        .ovf_raw  (ovf_raw)
    );

    // Report overflow only when the adder output is the result
    always_comb begin
        arith_op = (slice_sel_e'(op[1:0]) == SEL_SUM);
        overflow = ovf_raw & arith_op;
    end

    alu_zero_detect #(
        .WIDTH (WIDTH),
        .GROUP (8)
    ) u_zero (
        .word    (result),
        .is_zero (zero)
    );

endmodule

// File: rtl/alu_slt_checker.sv
// Property checker for alu_slt_core. The block has no clock, so it uses
// immediate assertions that are evaluated whenever the ports settle.
module alu_slt_checker
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic [2:0]       op,
    input logic [WIDTH-1:0] result,
    input logic             zero,
    input logic             overflow
);

    // Check port relations for each defined operation
    always_comb begin
        if (op == ALU_AND) begin
            // R1
            and_result_chk: assert (result == (a & b));
        end
        if (op == ALU_SLT) begin
            // R5
            slt_upper_clear_chk: assert (result[WIDTH-1:1] == '0);
            // R6
            slt_signed_chk: assert (result[0] == ($signed(a) < $signed(b)));
        end
        if (op == ALU_SUB && a == b) begin
            // R7
            equal_zero_chk: assert (zero && !overflow);
        end
        if (op == ALU_ADD && a[WIDTH-1] != b[WIDTH-1]) begin
            // R8
            mixed_add_no_ovf_chk: assert (!overflow);
        end
        if (op == ALU_OR || op == ALU_AND) begin
            // R10
            logic_no_ovf_chk: assert (!overflow);
        end
    end

endmodule

bind alu_slt_core alu_slt_checker #(.WIDTH(WIDTH)) u_alu_slt_checker (
    .a        (a),
    .b        (b),
    .op       (op),
    .result   (result),
    .zero     (zero),
    .overflow (overflow)
);

// File: tb/test_alu_slt_core.sv
module test_alu_slt_core;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;

    always #4 clk = ~clk;

    logic [31:0] a32 = '0, b32 = '0, r32;
    logic [2:0]  op32 = 3'b000;
    logic        z32, v32;
    logic [3:0]  a4 = '0, b4 = '0, r4;
    logic [2:0]  op4 = 3'b000;
    logic        z4, v4;

    alu_slt_core #(.WIDTH(32)) i_alu_slt_core (
        .a(a32), .b(b32), .op(op32), .result(r32), .zero(z32), .overflow(v32)
    );

    alu_slt_core #(.WIDTH(4)) i_alu_slt_core_narrow (
        .a(a4), .b(b4), .op(op4), .result(r4), .zero(z4), .overflow(v4)
    );

    // Reference: returns {overflow, zero, result} for a w-bit unit
    function automatic logic [33:0] model(input logic [31:0] a, input logic [31:0] b,
                                          input logic [2:0] op, input int w);
        logic [31:0] mask, r;
        logic        sa, sb, sr, ov;
        longint      va, vb;
        mask = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
        sa = a[w-1];
        sb = b[w-1];
        va = sa ? longint'(a) - (longint'(1) << w) : longint'(a);
        vb = sb ? longint'(b) - (longint'(1) << w) : longint'(b);
        ov = 1'b0;
        case (op)
            3'b000:  r = a & b;
            3'b001:  r = a | b;
            3'b010: begin
                r  = (a + b) & mask;
                sr = r[w-1];
                ov = (sa == sb) && (sr != sa);
            end
            3'b110: begin
                r  = (a - b) & mask;
                sr = r[w-1];
                ov = (sa != sb) && (sr != sa);
            end
            default: r = (va < vb) ? 32'd1 : 32'd0;
        endcase
        return {ov, (r == 32'd0), r};
    endfunction

    function automatic string res_tag(input logic [2:0] op);
        case (op)
            3'b000:  return "R1";
            3'b001:  return "R2";
            3'b010:  return "R3";
            3'b110:  return "R4";
            default: return "R5";
        endcase
    endfunction

    function automatic string ovf_tag(input logic [2:0] op);
        case (op)
            3'b010:  return "R8";
            3'b110:  return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run32(input logic [31:0] a, input logic [31:0] b, input logic [2:0] op,
                         input string extra);
        logic [33:0] e;
        @(negedge clk);
        a32 = a; b32 = b; op32 = op;
        #2;
        e = model(a, b, op, 32);
        check({res_tag(op), extra}, r32, e[31:0]);
        check({"R7", extra}, {31'd0, z32}, {31'd0, e[32]});
        check({ovf_tag(op), extra}, {31'd0, v32}, {31'd0, e[33]});
    endtask

    task automatic run4(input logic [3:0] a, input logic [3:0] b, input logic [2:0] op);
        logic [33:0] e;
        a4 = a; b4 = b; op4 = op;
        #1;
        e = model({28'd0, a}, {28'd0, b}, op, 4);
        check({res_tag(op), " w4"}, {28'd0, r4}, e[31:0]);
        check("R7 w4", {31'd0, z4}, {31'd0, e[32]});
        check({ovf_tag(op), " w4"}, {31'd0, v4}, {31'd0, e[33]});
    endtask

    // Pick one of the five defined operation codes
    function automatic logic [2:0] pick_op(input int unsigned k);
        case (k % 5)
            0:       return 3'b000;
            1:       return 3'b001;
            2:       return 3'b010;
            3:       return 3'b110;
            default: return 3'b111;
        endcase
    endfunction

    // Watchdog: an expired run counts as a failed check
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] corner [8];
        int unsigned seed;
        corner[0] = 32'h0000_0000; corner[1] = 32'h0000_0001;
        corner[2] = 32'h7FFF_FFFF; corner[3] = 32'h8000_0000;
        corner[4] = 32'hFFFF_FFFF; corner[5] = 32'h8000_0001;
        corner[6] = 32'h7FFF_FFFE; corner[7] = 32'h5555_AAAA;

        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Idle inputs (all zero, AND): result 0, zero 1, overflow 0
        #2;
        check("R1 idle", r32, 32'd0);
        check("R7 idle", {31'd0, z32}, 32'd1);
        check("R10 idle", {31'd0, v32}, 32'd0);

        // R6: the subtraction overflows but the comparison stays correct
        run32(32'h7FFF_FFFF, 32'h8000_0000, 3'b111, " R6 max<min");
        run32(32'h8000_0000, 32'h7FFF_FFFF, 3'b111, " R6 min<max");
        // R11: the top carry-out is dropped
        run32(32'hFFFF_FFFF, 32'h0000_0001, 3'b010, " R11 wrap");
        run32(32'h8000_0000, 32'h8000_0000, 3'b010, " R8 neg+neg");
        run32(32'h1234_5678, 32'h1234_5678, 3'b110, " R7 equal");

        // Every corner pair under every defined code
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++)
                for (int k = 0; k < 5; k++)
                    run32(corner[i], corner[j], pick_op(k), " corner");

        // Seeded random operands
        seed = 32'd20240611;
        void'($urandom(seed));
        for (int n = 0; n < 2000; n++)
            run32($urandom, $urandom, pick_op($urandom), " random");

        // Full sweep of the 4-bit unit
        for (int k = 0; k < 5; k++)
            for (int x = 0; x < 16; x++)
                for (int y = 0; y < 16; y++)
                    run4(4'(x), 4'(y), pick_op(k));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule